// File: doc/BRIEF.md
# Segmented Reservation-Station Entry Allocator

This block hands out reservation-station entries to instructions being dispatched. The entries are split into equal segments, and each segment has its own small finder that picks one free entry among its own few. Dispatch slot k is wired to segment k. Several instructions can therefore be placed in one cycle without a search across the whole station. The cost is that a slot whose segment is full cannot use free entries held by another segment.

Each entry is a two-state machine. ENT_FREE moves to ENT_BUSY on the ALLOC transition, when a slot is granted that entry. ENT_BUSY moves to ENT_FREE on the RELEASE transition, when the entry's bit is set in the release mask. All other cycles take the HOLD transition.

The free entries of all machines together form the availability vector, with one bit per entry and 1 meaning free. Grants and indices are computed combinationally from that vector in the request cycle. Dispatch is kept in program order: a requesting slot that cannot be served blocks every slot above it.

Top module: `rsa_seg_alloc`

## Requirements
- R1: After reset every entry is in ENT_FREE. While reset is held, each entry stays in ENT_FREE.
- R2: A granted slot k receives the lowest-numbered free entry of segment k. The index is the global entry number: bits [3:2] carry the segment and bits [1:0] carry the position inside it (4 segments of 4).
- R3: gnt_o[k] is asserted only when req_i[k] is asserted. Grant and index appear in the same cycle as the request, and the granted entry is busy from the next clock edge.
- R4: A requesting slot whose segment has no free entry is refused, even when other segments have free entries.
- R5: If a requesting slot k is refused, every slot above k is refused in that cycle. A slot that does not request does not block higher slots.
- R6: Entries whose bit is set in rel_mask_i become free at the clock edge. An entry released in a cycle cannot be granted in that same cycle.
- R7: When gnt_o[k] is low, the index field of slot k reads zero.
- R8: A busy entry is never granted again until it has been released. A release bit for an entry that is already free has no effect. When an entry is granted and its release bit is set in the same cycle, the allocation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SEG (4) | Per-slot dispatch request, slot k served by segment k |
| rel_mask_i | input | NUM_SEG*SEG_SIZE (16) | Entries to free at the next edge |
| gnt_o | output | NUM_SEG (4) | Per-slot grant, same cycle as the request |
| idx_o | output | NUM_SEG*IDX_W (16) | Packed entry indices, slot k in bits [4k+3:4k] |

## Verification
The bench uses the default build: four segments of four entries, with 4-bit indices. This small size means that a handful of grants fills a segment completely. Within a few vectors the bench reaches a full segment next to free ones, a refused slot that blocks the slots above it, and a release that shows up only in the following cycle. A release landing on a free entry that is granted in the same cycle, and a full-mask release that returns the station to its reset picture, are reached in the same short run.

// File: rtl/rsa_pkg.sv
`timescale 1ns/1ps
package rsa_pkg;
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_BUSY = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rsa_entry.sv
`timescale 1ns/1ps
// One station entry: ENT_FREE <-> ENT_BUSY (ALLOC, RELEASE, HOLD).
module rsa_entry
    import rsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_i,
    input  logic release_i,
    output logic free_o
);
    ent_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc_i)   state_d = ENT_BUSY;  // ALLOC beats a stray release
            ENT_BUSY: if (release_i) state_d = ENT_FREE;  // RELEASE
            default:                 state_d = ENT_FREE;
        endcase
    end

    always_comb begin
        free_o = (state_q == ENT_FREE);
    end
endmodule

// File: rtl/rsa_seg_pick.sv
`timescale 1ns/1ps
// 1-of-K finder: lowest-numbered free entry inside one segment.
module rsa_seg_pick #(
    parameter int K  = 4,
    parameter int LW = $clog2(K)
) (
    input  logic [K-1:0]  free_i,
    output logic          found_o,
    output logic [LW-1:0] loc_o
);
    always_comb begin
        found_o = |free_i;
        loc_o   = '0;
        for (int i = K - 1; i >= 0; i--) begin
            if (free_i[i]) loc_o = LW'(i);
        end
    end
endmodule

// File: rtl/rsa_order_gate.sv
`timescale 1ns/1ps
// In-order gate: a refused requesting slot blocks all higher slots.
module rsa_order_gate #(
    parameter int S = 4
) (
    input  logic [S-1:0] req_i,
    input  logic [S-1:0] found_i,
    output logic [S-1:0] gnt_o
);
    logic blocked;
    always_comb begin
        blocked = 1'b0;
        for (int k = 0; k < S; k++) begin
            gnt_o[k] = req_i[k] & found_i[k] & ~blocked;
            blocked  = blocked | (req_i[k] & ~found_i[k]);
        end
    end
endmodule

// File: rtl/rsa_seg_alloc.sv
`timescale 1ns/1ps
module rsa_seg_alloc #(
    parameter int NUM_SEG  = 4,
    parameter int SEG_SIZE = 4,
    localparam int N_ENT   = NUM_SEG * SEG_SIZE,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int LOC_W   = $clog2(SEG_SIZE),
    localparam int SEG_W   = IDX_W - LOC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SEG-1:0]       req_i,
    input  logic [N_ENT-1:0]         rel_mask_i,
    output logic [NUM_SEG-1:0]       gnt_o,
    output logic [NUM_SEG*IDX_W-1:0] idx_o
);
    logic [N_ENT-1:0]   avail;
    logic [N_ENT-1:0]   alloc_vec;
    logic [NUM_SEG-1:0] found;
    logic [LOC_W-1:0]   loc [NUM_SEG];

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        rsa_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_vec[e]),
            .release_i (rel_mask_i[e]),
            .free_o    (avail[e])
        );
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        rsa_seg_pick #(.K(SEG_SIZE), .LW(LOC_W)) u_pick (
            .free_i  (avail[s*SEG_SIZE +: SEG_SIZE]),
            .found_o (found[s]),
            .loc_o   (loc[s])
        );

        always_comb begin
            idx_o[s*IDX_W +: IDX_W] = gnt_o[s] ? {SEG_W'(s), loc[s]} : '0;
            for (int j = 0; j < SEG_SIZE; j++) begin
                alloc_vec[s*SEG_SIZE + j] = gnt_o[s] && (loc[s] == LOC_W'(j));
            end
        end
    end

    rsa_order_gate #(.S(NUM_SEG)) u_order (
        .req_i   (req_i),
        .found_i (found),
        .gnt_o   (gnt_o)
    );
endmodule

// File: rtl/rsa_seg_alloc_chk.sv
`timescale 1ns/1ps
module rsa_seg_alloc_chk #(
    parameter int NUM_SEG  = 4,
    parameter int SEG_SIZE = 4,
    localparam int N_ENT   = NUM_SEG * SEG_SIZE,
    localparam int IDX_W   = $clog2(N_ENT)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SEG-1:0]       req_i,
    input logic [N_ENT-1:0]         rel_mask_i,
    input logic [NUM_SEG-1:0]       gnt_o,
    input logic [NUM_SEG*IDX_W-1:0] idx_o
);
    // Shadow occupancy rebuilt from port activity only.
    logic [N_ENT-1:0] busy_sh;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_sh <= '0;
        end else begin
            for (int e = 0; e < N_ENT; e++) begin
                if (rel_mask_i[e]) busy_sh[e] <= 1'b0;
            end
            for (int k = 0; k < NUM_SEG; k++) begin
                if (gnt_o[k]) busy_sh[idx_o[k*IDX_W +: IDX_W]] <= 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_chk
        logic lower_fail;
        if (k == 0) begin : g_l0
            assign lower_fail = 1'b0;
        end else begin : g_ln
            assign lower_fail = |(req_i[k-1:0] & ~gnt_o[k-1:0]);
        end

        p_gnt_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[k] |-> req_i[k]);
        p_idx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_o[k] |-> (idx_o[k*IDX_W +: IDX_W] == '0));
        p_no_busy_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[k] |-> !busy_sh[idx_o[k*IDX_W +: IDX_W]]);
        p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
            lower_fail |-> !gnt_o[k]);
        p_refuse_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[k] && !gnt_o[k] && !lower_fail) |->
                (&busy_sh[k*SEG_SIZE +: SEG_SIZE]));
    end
endmodule

bind rsa_seg_alloc rsa_seg_alloc_chk #(.NUM_SEG(NUM_SEG), .SEG_SIZE(SEG_SIZE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .rel_mask_i (rel_mask_i),
    .gnt_o      (gnt_o),
    .idx_o      (idx_o)
);

// File: tb/rsa_seg_alloc_test.sv
`timescale 1ns/1ps
module rsa_seg_alloc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_i = '0;
    logic [15:0] rel_mask_i = '0;
    logic [3:0]  gnt_o;
    logic [15:0] idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rsa_seg_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rel_mask_i(rel_mask_i),
        .gnt_o(gnt_o), .idx_o(idx_o)
    );

    // {req, release mask, expected grant, expected packed indices}
    localparam int NV = 15;
    localparam logic [39:0] VEC [NV] = '{
        {4'b1111, 16'h0000, 4'b1111, 16'hC840}, // 0  R1 R2
        {4'b1111, 16'h0000, 4'b1111, 16'hD951}, // 1  R2 R3
        {4'b0001, 16'h0000, 4'b0001, 16'h0002}, // 2  R2 R7
        {4'b0001, 16'h0000, 4'b0001, 16'h0003}, // 3  seg0 now full
        {4'b1111, 16'h0000, 4'b0000, 16'h0000}, // 4  R4 R5
        {4'b1110, 16'h0000, 4'b1110, 16'hEA60}, // 5  R5 idle slot0 no block
        {4'b0001, 16'h0004, 4'b0000, 16'h0000}, // 6  R6 release not usable yet
        {4'b0011, 16'h0000, 4'b0011, 16'h0072}, // 7  R6 released entry 2 reused
        {4'b1110, 16'h0000, 4'b0000, 16'h0000}, // 8  R5 slot1 full blocks 2,3
        {4'b1100, 16'h0801, 4'b1100, 16'hFB00}, // 9  R8 stray release on 11
        {4'b0100, 16'h0000, 4'b0000, 16'h0000}, // 10 R8 entry 11 stayed busy
        {4'b1111, 16'h0000, 4'b0001, 16'h0000}, // 11 R5 R7 entry 0 granted
        {4'b0000, 16'hFFFF, 4'b0000, 16'h0000}, // 12 R6 release all
        {4'b1111, 16'h0000, 4'b1111, 16'hC840}, // 13 R6 all free again
        {4'b0010, 16'h0000, 4'b0010, 16'h0050}  // 14 R2 R4
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R1/R2";
            4:       return "R4/R5";
            5, 8:    return "R5";
            6, 7:    return "R6";
            9, 10:   return "R8";
            11:      return "R5/R7";
            12, 13:  return "R6";
            default: return "R2/R3";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] eg, logic [15:0] ei);
        n_chk++;
        if (gnt_o !== eg || idx_o !== ei) begin
            n_bad++;
            $display("FAIL %s: gnt=%b idx=%h expected gnt=%b idx=%h", tag, gnt_o, idx_o, eg, ei);
        end
    endtask

    task automatic apply(logic [3:0] rq, logic [15:0] rl);
        @(negedge clk);
        req_i = rq;
        rel_mask_i = rl;
        #5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R1 reset idle", 4'b0000, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][39:36], VEC[i][35:20]);
            check(vec_tag(i), VEC[i][19:16], VEC[i][15:0]);
        end

        // State now: entries 0,4,5,8,12 busy. Slot0 next gets 1.
        apply(4'b0001, 16'h0000);
        check("R2 before reset", 4'b0001, 16'h0001);
        @(negedge clk);
        req_i = '0; rel_mask_i = '0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(4'b1111, 16'h0000);
        check("R1 after mid-run reset", 4'b1111, 16'hC840);
        apply(4'b0000, 16'h0000);
        check("R7 no requests", 4'b0000, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule